// File: doc/BRIEF.md
# Serial Register Access Interface

This block is a serial slave that lets a host read and write a small bank of configuration, calibration and result registers. It uses four wires: an active-low select, a serial clock that idles high, a data input, and one output line with its own enable. The serial inputs are brought into a faster system clock through a synchroniser, and their edges are detected in that clock domain. Every access opens with an 8-bit command, most significant bit first. The command names the direction and one of eight register addresses. The data phase that follows is 8, 16 or `DATA_W` bits long, depending on the address.

When a transfer is not under way, the output line shows an active-low ready flag. A strobe from the converter core loads a new result and pulls the flag low. Reading the result register raises the flag again. A continuous-read mode lets the host pull each new result out without sending a command first. Holding the data input high for a long run of serial clocks returns the entire block to its reset state, which gives the host a way to regain alignment.

Top module: `sra_serial_if`

## Requirements
- R1: After reset, the output enable is high only while select is low. With select low and no transfer under way, the output line shows the ready flag, which is 1 after reset.
- R2: The command byte is shifted in MSB first. While the command bit counter sits at its first position, a sampled 1 is discarded, so any number of leading 1 bits is skipped until a 0 arrives.
- R3: In the command, bit 6 selects read (1) or write (0), bits 5:3 give the address and bit 2 requests continuous read. Addresses 1 and 2 transfer 16 bits. Addresses 3, 6 and 7 transfer DATA_W bits. Addresses 0, 4 and 5 transfer 8 bits. After the data phase the block waits for a new command.
- R4: Data is sent MSB first. Writes to address 1 (mode), 2 (configuration), 5 (port), 6 (offset) and 7 (gain) are stored and read back. Reset values are 0x000A, 0x0710, 0x00, 0x800000 and 0x500000, with the last two aligned to DATA_W=24. Address 4 reads the identity code 0x09.
- R5: Writes to address 0, address 3 (result) and address 4 (identity) have no effect on any register or on the ready flag.
- R6: A result_valid pulse loads result_data into the result register and drives the ready flag to 0. A completed read of address 3 sets the ready flag back to 1. In normal mode the same result may be read again.
- R7: Output data changes after a falling serial clock edge and holds through the following rising edge. The output enable goes low whenever select is high.
- R8: Command 0x5C enables continuous read. In that mode, a falling edge while ready is 0 starts a DATA_W-bit result transfer with no command. Each result is sent only once: while ready is 1, no transfer starts and the line reads 1.
- R9: In continuous-read mode, the host can leave the mode only by sending command 0x58 while ready is 0. Any other command, and 0x58 sent while ready is 1, is ignored. After the mode is left, the current result is still unread.
- R10: If 32 consecutive rising serial clock edges with select low all sample the data input high, the whole block resets: all registers, the ready flag and continuous read. A run of 31 ones followed by a 0 has no effect.
- R11: Raising select abandons any partial command or data phase without writing anything. The next bits after select goes low again are taken as a new command.
- R12: Address 0 reads the status byte. Bit 7 is the ready flag, bit 3 is 1 when DATA_W exceeds 16, bits 2:0 copy configuration bits 2:0, and the other bits are 0. With DATA_W=24, the value after reset is 0x88.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select, asynchronous to clk |
| sclk | input | 1 | Serial clock, idles high, asynchronous to clk |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| result_valid | input | 1 | One-cycle strobe marking a new conversion result |
| result_data | input | DATA_W | Conversion result captured on result_valid |
| sdo | output | 1 | Serial data out, or the ready flag when idle |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |

## Verification
The bench targets the write-enable gate with several leading ones in a row. A design without the gate would shift those ones into the command and decode the wrong address. It also sends the exit command while no result is waiting, and checks that the following result still streams: a design that exits regardless of the flag would stop streaming there. The ones-run reset is tested at 31 and at 32 ones, and from inside continuous-read mode, which catches off-by-one counters and counters that are not cleared by zero bits. Raising select in the middle of a command and in the middle of a write checks that a partial transfer neither lands in a register nor shifts the alignment of the next command.

// File: rtl/sra_pkg.sv
package sra_pkg;
    // Protocol state of the serial slave
    typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD} sra_state_e;

    localparam int LEN_W = 6;

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_MODE = 3'd1;
    localparam logic [2:0] A_CONF = 3'd2;
    localparam logic [2:0] A_DATA = 3'd3;
    localparam logic [2:0] A_IDC  = 3'd4;
    localparam logic [2:0] A_PORT = 3'd5;
    localparam logic [2:0] A_OFFS = 3'd6;
    localparam logic [2:0] A_GAIN = 3'd7;

    localparam logic [7:0] CMD_STREAM_ON  = 8'h5C;
    localparam logic [7:0] CMD_STREAM_OFF = 8'h58;

    // Data-phase length in bits for a register address
    function automatic logic [LEN_W-1:0] reg_bits(input logic [2:0] a,
                                                  input logic [LEN_W-1:0] wide);
        unique case (a)
            A_MODE, A_CONF:         reg_bits = LEN_W'(16);
            A_DATA, A_OFFS, A_GAIN: reg_bits = wide;
            default:                reg_bits = LEN_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/sra_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherence is implied.
module sra_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level
);
    logic [W-1:0] pipe [STAGES];

    // Shift the inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
        end else begin
            pipe[0] <= async_in;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign level = pipe[STAGES-1];
endmodule

// File: rtl/sra_edge_det.sv
// Single-bit edge detector on an already synchronised level.
// Assumes the input is stable in the clk domain.
module sra_edge_det #(
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= INIT;
        else        prev <= level;
    end

    assign rise = level & ~prev;
    assign fall = ~level & prev;
endmodule

// File: rtl/sra_regbank.sv
// Register storage: mode, configuration, port, offset, gain, result and
// the ready flag. Assumes at most one write per cycle; reads are combinational.
module sra_regbank
    import sra_pkg::*;
#(
    parameter int         DATA_W  = 24,
    parameter logic [7:0] ID_CODE = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              data_taken,
    output logic              ready_n
);
    localparam logic [DATA_W-1:0] OFFS_INIT = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] GAIN_INIT = DATA_W'(32'h5000) << (DATA_W - 16);
    localparam logic              WIDE      = (DATA_W > 16);

    logic [15:0]       mode_q, conf_q;
    logic [7:0]        port_q;
    logic [DATA_W-1:0] offs_q, gain_q, data_q;

    // Host-writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 16'h000A;
            conf_q <= 16'h0710;
            port_q <= 8'h00;
            offs_q <= OFFS_INIT;
            gain_q <= GAIN_INIT;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_MODE:  mode_q <= wr_data[15:0];
                A_CONF:  conf_q <= wr_data[15:0];
                A_PORT:  port_q <= wr_data[7:0];
                A_OFFS:  offs_q <= wr_data;
                A_GAIN:  gain_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Result capture and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            ready_n <= 1'b1;
        end else if (res_valid) begin
            data_q  <= res_data;
            ready_n <= 1'b0;
        end else if (data_taken) begin
            ready_n <= 1'b1;
        end
    end

    // Read multiplexer
    always_comb begin
        unique case (rd_addr)
            A_STAT:  rd_data = DATA_W'({ready_n, 3'b000, WIDE, conf_q[2:0]});
            A_MODE:  rd_data = DATA_W'(mode_q);
            A_CONF:  rd_data = DATA_W'(conf_q);
            A_DATA:  rd_data = data_q;
            A_IDC:   rd_data = DATA_W'(ID_CODE);
            A_PORT:  rd_data = DATA_W'(port_q);
            A_OFFS:  rd_data = offs_q;
            default: rd_data = gain_q;
        endcase
    end

    a_r6_ready_on_result: assert property (@(posedge clk)
        rst_n && res_valid |=> !ready_n);
    a_r6_ready_after_take: assert property (@(posedge clk)
        rst_n && data_taken && !res_valid |=> ready_n);
endmodule

// File: rtl/sra_serial_if.sv
// Serial slave: command decode, data phases, continuous read, ones-run
// resynchronisation and the ready indication on the output line.
// Assumes sclk half periods span several clk cycles.
module sra_serial_if
    import sra_pkg::*;
#(
    parameter int         DATA_W      = 24,
    parameter int         SYNC_STAGES = 2,
    parameter int         ONES_LIMIT  = 32,
    parameter logic [7:0] ID_CODE     = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              result_valid,
    input  logic [DATA_W-1:0] result_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int              ONES_W = $clog2(ONES_LIMIT + 1);
    localparam logic [LEN_W-1:0] WIDE_LEN = LEN_W'(DATA_W);

    logic [2:0]        lvl;
    logic              cs_hi, sclk_s, sdi_s, sclk_rise_raw, sclk_fall_raw;
    logic              sclk_rise, sclk_fall;
    sra_state_e        state;
    logic              stream, sdo_q, ready_n, soft_rst, core_rst_n;
    logic [2:0]        cmd_cnt, cur_addr, new_addr, rd_addr;
    logic [6:0]        cmd_sr;
    logic [7:0]        cmd_word;
    logic [LEN_W-1:0]  bit_cnt, cur_len, new_len;
    logic [ONES_W-1:0] ones_cnt;
    logic [DATA_W-1:0] out_sr, rd_data, wr_data;
    logic [DATA_W-2:0] in_sr;
    logic              cmd_active, cmd_take, cmd_done, last_bit, xfer_end;
    logic              stream_start, exit_hit, wr_en, data_taken;

    sra_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b011)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in({sdi, sclk, cs_n}), .level(lvl));
    assign {sdi_s, sclk_s, cs_hi} = lvl;

    sra_edge_det #(.INIT(1'b1)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .level(sclk_s),
        .rise(sclk_rise_raw), .fall(sclk_fall_raw));

    assign sclk_rise  = sclk_rise_raw & ~cs_hi;
    assign sclk_fall  = sclk_fall_raw & ~cs_hi;
    assign soft_rst   = sclk_rise & sdi_s & (ones_cnt == ONES_W'(ONES_LIMIT - 1));
    assign core_rst_n = rst_n & ~soft_rst;

    // Command decode and data-phase bookkeeping
    assign cmd_active   = stream | (state == ST_CMD);
    assign cmd_take     = sclk_rise & cmd_active & ~((cmd_cnt == 3'd0) & sdi_s);
    assign cmd_done     = cmd_take & (cmd_cnt == 3'd7);
    assign cmd_word     = {cmd_sr, sdi_s};
    assign new_addr     = cmd_word[5:3];
    assign new_len      = reg_bits(new_addr, WIDE_LEN);
    assign cur_len      = reg_bits(cur_addr, WIDE_LEN);
    assign last_bit     = (bit_cnt == cur_len - LEN_W'(1));
    assign xfer_end     = sclk_rise & (state != ST_CMD) & last_bit;
    assign stream_start = stream & (state == ST_CMD) & sclk_fall & ~ready_n;
    assign exit_hit     = stream & cmd_done & (cmd_word == CMD_STREAM_OFF) & ~ready_n;
    assign wr_en        = xfer_end & (state == ST_WR);
    assign wr_data      = {in_sr, sdi_s};
    assign data_taken   = xfer_end & (state == ST_RD) & (cur_addr == A_DATA) & ~exit_hit;
    assign rd_addr      = stream ? A_DATA : new_addr;

    sra_regbank #(.DATA_W(DATA_W), .ID_CODE(ID_CODE)) u_regs (
        .clk(clk), .rst_n(core_rst_n), .wr_en(wr_en), .wr_addr(cur_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .res_valid(result_valid), .res_data(result_data),
        .data_taken(data_taken), .ready_n(ready_n));

    // Protocol sequencer
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            state    <= ST_CMD;
            stream   <= 1'b0;
            cmd_cnt  <= '0;
            cmd_sr   <= '0;
            bit_cnt  <= '0;
            cur_addr <= A_STAT;
            out_sr   <= '0;
            in_sr    <= '0;
            sdo_q    <= 1'b1;
            ones_cnt <= '0;
        end else if (cs_hi) begin
            state    <= ST_CMD;
            cmd_cnt  <= '0;
            bit_cnt  <= '0;
            ones_cnt <= '0;
        end else begin
            if (sclk_rise) ones_cnt <= sdi_s ? ones_cnt + ONES_W'(1) : '0;
            if (cmd_take) begin
                cmd_sr  <= cmd_word[6:0];
                cmd_cnt <= cmd_cnt + 3'd1;
            end
            unique case (state)
                ST_CMD: begin
                    if (stream_start) begin
                        state    <= ST_RD;
                        cur_addr <= A_DATA;
                        bit_cnt  <= '0;
                        cmd_cnt  <= '0;
                        sdo_q    <= rd_data[DATA_W-1];
                        out_sr   <= rd_data << 1;
                    end else if (cmd_done && !stream) begin
                        cur_addr <= new_addr;
                        bit_cnt  <= '0;
                        if (!cmd_word[6]) begin
                            state <= ST_WR;
                        end else if (cmd_word[2] && new_addr == A_DATA) begin
                            stream <= 1'b1;
                        end else begin
                            state  <= ST_RD;
                            out_sr <= rd_data << (WIDE_LEN - new_len);
                        end
                    end
                end
                ST_WR: begin
                    if (sclk_rise) begin
                        in_sr   <= wr_data[DATA_W-2:0];
                        bit_cnt <= bit_cnt + LEN_W'(1);
                        if (last_bit) state <= ST_CMD;
                    end
                end
                default: begin
                    if (sclk_fall) begin
                        sdo_q  <= out_sr[DATA_W-1];
                        out_sr <= out_sr << 1;
                    end
                    if (sclk_rise) begin
                        bit_cnt <= bit_cnt + LEN_W'(1);
                        if (last_bit) begin
                            state   <= ST_CMD;
                            cmd_cnt <= '0;
                        end
                    end
                end
            endcase
            if (exit_hit) begin
                stream  <= 1'b0;
                state   <= ST_CMD;
                cmd_cnt <= '0;
            end
        end
    end

    assign sdo    = (state == ST_RD) ? sdo_q : ready_n;
    assign sdo_oe = ~cs_hi;

    a_r11_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (state == ST_CMD) && (cmd_cnt == 3'd0));
    a_r10_ones_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !stream && (state == ST_CMD) && (ones_cnt == '0));
    a_r9_exit_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stream) |-> $past(soft_rst) || $past(!ready_n));
    a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CMD) |-> (bit_cnt < cur_len));
    a_r8_stream_reads_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD) && stream |-> (cur_addr == A_DATA));
endmodule

// File: tb/sra_serial_if_tb.sv
module sra_serial_if_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        result_valid = 1'b0;
    logic [23:0] result_data = '0;
    logic        sdo, sdo_oe;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] rx;

    always #2.5 clk = ~clk;

    sra_serial_if u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .result_valid(result_valid), .result_data(result_data),
        .sdo(sdo), .sdo_oe(sdo_oe));

    function automatic int lenf(input logic [2:0] a);
        if (a == 3'd1 || a == 3'd2) return 16;
        if (a == 3'd3 || a == 3'd6 || a == 3'd7) return 24;
        return 8;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic di, output logic lo, output logic hi);
        @(negedge clk);
        sclk = 1'b0;
        sdi  = di;
        wait_clk(HALF);
        lo   = sdo;
        sclk = 1'b1;
        wait_clk(HALF);
        hi   = sdo;
    endtask

    task automatic shift(input logic [31:0] tx, input int n, output logic [31:0] r);
        logic lo, hi;
        r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            bit_io(tx[i], lo, hi);
            r = {r[30:0], lo};
        end
        sdi = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        logic [31:0] d;
        shift({24'd0, 2'b01, a, 3'b000}, 8, d);
        shift(32'd0, lenf(a), v);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        logic [31:0] d;
        shift({24'd0, 2'b00, a, 3'b000}, 8, d);
        shift(v, lenf(a), d);
    endtask

    task automatic select();
        @(negedge clk); cs_n = 1'b0; wait_clk(6);
    endtask

    task automatic deselect();
        @(negedge clk); cs_n = 1'b1; wait_clk(6);
    endtask

    task automatic push_result(input logic [23:0] v);
        @(negedge clk); result_valid = 1'b1; result_data = v;
        @(negedge clk); result_valid = 1'b0;
        wait_clk(3);
    endtask

    task automatic t_reset();
        check("R7 oe low while deselected", {31'd0, sdo_oe}, 32'd0);
        select();
        check("R1 oe high when selected", {31'd0, sdo_oe}, 32'd1);
        check("R1 idle line shows ready=1", {31'd0, sdo}, 32'd1);
        rd_reg(3'd0, rx); check("R12 status after reset", rx, 32'h88);
        rd_reg(3'd1, rx); check("R4 mode default", rx, 32'h000A);
        rd_reg(3'd2, rx); check("R4 config default", rx, 32'h0710);
        rd_reg(3'd5, rx); check("R4 port default", rx, 32'h00);
        rd_reg(3'd6, rx); check("R4 offset default", rx, 32'h800000);
        rd_reg(3'd7, rx); check("R4 gain default", rx, 32'h500000);
        rd_reg(3'd4, rx); check("R4 identity code", rx, 32'h09);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        shift(32'h7, 3, d);
        rd_reg(3'd4, rx); check("R2 leading ones skipped", rx, 32'h09);
    endtask

    task automatic t_write_read();
        wr_reg(3'd1, 32'h1234); rd_reg(3'd1, rx); check("R4 mode write", rx, 32'h1234);
        wr_reg(3'd5, 32'hA5);   rd_reg(3'd5, rx); check("R3 port 8-bit", rx, 32'hA5);
        wr_reg(3'd6, 32'h13579B); rd_reg(3'd6, rx); check("R3 offset 24-bit", rx, 32'h13579B);
        wr_reg(3'd7, 32'h2468AC); rd_reg(3'd7, rx); check("R4 gain write", rx, 32'h2468AC);
        wr_reg(3'd2, 32'h0005); rd_reg(3'd0, rx); check("R12 status channel bits", rx, 32'h8D);
        rd_reg(3'd2, rx); check("R3 config 16-bit", rx, 32'h0005);
    endtask

    task automatic t_ignored();
        wr_reg(3'd4, 32'h5A);
        wr_reg(3'd0, 32'h00);
        wr_reg(3'd3, 32'h123456);
        rd_reg(3'd4, rx); check("R5 identity unchanged", rx, 32'h09);
        rd_reg(3'd3, rx); check("R5 result unchanged", rx, 32'h0);
        rd_reg(3'd0, rx); check("R5 status unchanged", rx, 32'h8D);
    endtask

    task automatic t_edges();
        logic [31:0] d;
        logic lo, hi;
        int bad = 0;
        logic [7:0] got = '0;
        shift({24'd0, 8'h68}, 8, d);
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b0, lo, hi);
            got[i] = lo;
            if (i > 0 && hi !== lo) bad++;
        end
        check("R7 data valid at rising edge", {24'd0, got}, 32'hA5);
        check("R7 data held through rising edge", bad, 0);
    endtask

    task automatic t_ready();
        push_result(24'hABCDEF);
        check("R6 line low on new result", {31'd0, sdo}, 32'd0);
        rd_reg(3'd3, rx); check("R6 result read", rx, 32'hABCDEF);
        check("R6 ready high after read", {31'd0, sdo}, 32'd1);
        rd_reg(3'd3, rx); check("R6 result re-read", rx, 32'hABCDEF);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        shift(32'h4, 4, d);
        deselect(); select();
        rd_reg(3'd1, rx); check("R11 aligned after command abort", rx, 32'h1234);
        shift(32'h08, 8, d);
        shift(32'h00CC, 8, d);
        deselect(); select();
        rd_reg(3'd1, rx); check("R11 partial write dropped", rx, 32'h1234);
    endtask

    task automatic t_stream();
        logic [31:0] d;
        shift(32'h5C, 8, d);
        push_result(24'h111111);
        shift(32'd0, 24, rx); check("R8 first streamed result", rx, 32'h111111);
        check("R8 ready high after stream read", {31'd0, sdo}, 32'd1);
        shift(32'd0, 24, rx); check("R8 no second read of same result", rx, 32'hFFFFFF);
        push_result(24'h222222);
        shift(32'd0, 24, rx); check("R8 next streamed result", rx, 32'h222222);
        shift(32'h48, 8, d);
        shift(32'h58, 8, d);
        push_result(24'h333333);
        shift(32'd0, 24, rx); check("R9 exit ignored while ready high", rx, 32'h333333);
        push_result(24'h444444);
        shift(32'h58, 8, d);
        check("R9 result still pending after exit", {31'd0, sdo}, 32'd0);
        shift(32'h58, 8, d);
        shift(32'd0, 24, rx); check("R9 normal read after exit", rx, 32'h444444);
    endtask

    task automatic t_ones();
        logic [31:0] d;
        shift(32'h7FFFFFFF, 31, d);
        rd_reg(3'd1, rx); check("R10 31 ones no reset", rx, 32'h1234);
        shift(32'h5C, 8, d);
        shift(32'hFFFFFFFF, 32, d);
        rd_reg(3'd1, rx); check("R10 32 ones reset mode", rx, 32'h000A);
        rd_reg(3'd0, rx); check("R10 status back to default", rx, 32'h88);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_gate();
        t_write_read();
        t_ignored();
        t_edges();
        t_ready();
        t_abort();
        t_stream();
        t_ones();
        deselect();
        check("R7 oe low after deselect", {31'd0, sdo_oe}, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule